// File: doc/BRIEF.md
# Fractional-N Divider Modulus Controller

This block steers a dual-modulus feedback divider so that, averaged over many output periods, the division ratio equals N + frac/2^F. It runs on the oscillator clock. The block counts that clock to produce one output pulse per division. At the start of each division it chooses whether that division lasts N or N+1 clocks, and it reports the choice for as long as the division lasts.

The choice comes from one of three sequencing schemes. The periodic scheme overflows a phase accumulator, which gives a fixed repeating pattern. The randomized scheme compares a pseudo-random register with the fraction, which turns the fixed pattern into noise. The shaped scheme is a first-order error-feedback modulator whose residue starts at mid-scale, so its quantization error is pushed toward high frequencies. Inputs are sampled only when one division ends and the next begins.

The controller is a two-state machine. ST_INIT is the reset state. The transition `start` (ST_INIT to ST_RUN) is taken on the first clock after reset is released and begins the first division. ST_RUN counts down. Its transition `reload` (ST_RUN to ST_RUN, when the count reaches zero) ends one division and begins the next.

Top module: `fracn_modctl`

## Requirements
- R1: While rst_n is low, div_out and plus_one are 0. The first division begins on the first rising clock edge after rst_n goes high, and its clocks are counted from that edge.
- R2: Every division lasts exactly len clocks, where len = n_in + plus_one. div_out is 1 only on the last clock of a division. plus_one stays constant for the whole division.
- R3: n_in, frac_in, mode_in and seed_in are used only at a division boundary. A change made in the middle of a division leaves that division's length unchanged and takes effect in the next division.
- R4: Periodic mode (mode_in = 0, and also the value 3) keeps an F-bit accumulator. The accumulator is cleared to 0 when this mode is entered. At each boundary it adds frac_in, and a carry out selects N+1 for the division that begins there. Example: N=4 and frac=64 give lengths 4,4,4,5, which is 17 clocks per 4 outputs.
- R5: Shaped mode (mode_in = 2) uses the same carry rule, but its residue is set to 2^(F-1) when the mode is entered. Example: N=4 and frac=64 give lengths 4,5,4,4.
- R6: In periodic and shaped modes, with n_in and frac_in held fixed, any 2^F consecutive divisions sum to exactly n_in·2^F + frac_in clocks.
- R7: Randomized mode (mode_in = 1) uses a 16-bit shift register that shifts left, with the new bit 0 equal to q[15]^q[13]^q[12]^q[10]. The register is loaded with seed_in when this mode is entered, and a seed of 0 is replaced by 16'hACE1. At each boundary, N+1 is chosen when the top F bits are less than frac_in, and then the register advances one step. The register is never zero while the block runs.
- R8: In randomized mode, over 16·2^F divisions, the number of N+1 divisions lies within 2^(F-1) of 16·frac_in.
- R9: With frac_in = 0, every division lasts exactly n_in clocks, in every mode.
- R10: Any change in the value of mode_in reloads the starting state of the newly selected mode at the next boundary. The first boundary after reset counts as a change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock that is divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| n_in | input | NW | Base modulus N, must be at least 2 |
| frac_in | input | F | Fractional word; average ratio is N + frac/2^F |
| mode_in | input | 2 | 0/3 periodic, 1 randomized, 2 shaped |
| seed_in | input | 16 | Seed for the randomized mode |
| div_out | output | 1 | One-clock pulse on the last clock of each division |
| plus_one | output | 1 | 1 when the current division lasts N+1 clocks |

## Verification
The bench builds the block with its default parameters: a 6-bit base modulus and an 8-bit fraction. With these values a full fractional cycle of 256 divisions takes only a few thousand clocks, so the bench can run whole windows many times and compare each window's clock total with N·256 + frac. The 8-bit fraction also allows a randomized run of 4096 divisions, long enough to test the proportion of N+1 divisions against a fixed tolerance. Both the end value frac=255 and the value frac=0 are tested directly.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

    typedef enum logic [1:0] {
        MODE_PERIODIC = 2'd0,
        MODE_RANDOM   = 2'd1,
        MODE_SHAPED   = 2'd2,
        MODE_ALT_PER  = 2'd3
    } fracn_mode_e;

    typedef enum logic {
        ST_INIT = 1'b0,
        ST_RUN  = 1'b1
    } cnt_state_e;

    localparam logic [15:0] SEED_FALLBACK = 16'hACE1;

    function automatic logic [15:0] lfsr_step(input logic [15:0] q);
        return {q[14:0], q[15] ^ q[13] ^ q[12] ^ q[10]};
    endfunction

endpackage

// File: rtl/fracn_seq.sv
module fracn_seq
    import fracn_pkg::*;
#(
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          first,
    input  logic [1:0]    mode_in,
    input  logic [FW-1:0] frac_in,
    input  logic [15:0]   seed_in,
    output logic          sel,
    output logic [15:0]   lfsr_o
);
    localparam logic [FW-1:0] HALF = FW'(1) << (FW - 1);

    logic [FW-1:0] acc_q, base_acc, acc_nxt;
    logic [15:0]   lfsr_q, base_lfsr, lfsr_nxt;
    logic [1:0]    mode_q;
    logic          reload, carry, rnd_pick;
    logic [FW:0]   sum;

    always_comb begin
        reload    = first || (mode_in != mode_q);
        base_acc  = acc_q;
        base_lfsr = lfsr_q;
        if (reload) begin
            base_acc  = (fracn_mode_e'(mode_in) == MODE_SHAPED) ? HALF : '0;
            base_lfsr = (seed_in == 16'd0) ? SEED_FALLBACK : seed_in;
        end
        sum      = {1'b0, base_acc} + {1'b0, frac_in};
        carry    = sum[FW];
        rnd_pick = base_lfsr[15 -: FW] < frac_in;
        unique case (fracn_mode_e'(mode_in))
            MODE_RANDOM: begin
                sel      = rnd_pick;
                acc_nxt  = base_acc;
                lfsr_nxt = lfsr_step(base_lfsr);
            end
            MODE_PERIODIC, MODE_SHAPED, MODE_ALT_PER: begin
                sel      = carry;
                acc_nxt  = sum[FW-1:0];
                lfsr_nxt = base_lfsr;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            lfsr_q <= SEED_FALLBACK;
            mode_q <= '0;
        end else if (step) begin
            acc_q  <= acc_nxt;
            lfsr_q <= lfsr_nxt;
            mode_q <= mode_in;
        end
    end

    assign lfsr_o = lfsr_q;

endmodule

// File: rtl/fracn_count.sv
module fracn_count
    import fracn_pkg::*;
#(
    parameter int NW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] n_in,
    input  logic          sel,
    output logic          boundary,
    output logic          first,
    output logic          running,
    output logic          div_out,
    output logic          plus_one,
    output logic [NW:0]   cnt_o,
    output logic [NW:0]   len_o
);
    cnt_state_e  state_q, state_d;
    logic [NW:0] cnt_q, len_q, len_nxt;
    logic        plus_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    // transitions: start (INIT->RUN), reload (RUN->RUN at zero count)
    always_comb begin
        unique case (state_q)
            ST_INIT: state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        first    = (state_q == ST_INIT);
        running  = (state_q == ST_RUN);
        div_out  = running && (cnt_q == '0);
        boundary = first || div_out;
        plus_one = plus_q;
        cnt_o    = cnt_q;
        len_o    = len_q;
        len_nxt  = {1'b0, n_in} + {{NW{1'b0}}, sel};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            len_q  <= '0;
            plus_q <= 1'b0;
        end else if (boundary) begin
            cnt_q  <= len_nxt - 1'b1;
            len_q  <= len_nxt;
            plus_q <= sel;
        end else begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/fracn_modctl.sv
module fracn_modctl
    import fracn_pkg::*;
#(
    parameter int NW = 6,
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] n_in,
    input  logic [FW-1:0] frac_in,
    input  logic [1:0]    mode_in,
    input  logic [15:0]   seed_in,
    output logic          div_out,
    output logic          plus_one
);
    logic          boundary_w, first_w, running_w, sel_w;
    logic [NW:0]   cnt_w, len_w;
    logic [15:0]   lfsr_w;

    fracn_seq #(.FW(FW)) seq_i (
        .clk(clk), .rst_n(rst_n), .step(boundary_w), .first(first_w),
        .mode_in(mode_in), .frac_in(frac_in), .seed_in(seed_in),
        .sel(sel_w), .lfsr_o(lfsr_w)
    );

    fracn_count #(.NW(NW)) cnt_i (
        .clk(clk), .rst_n(rst_n), .n_in(n_in), .sel(sel_w),
        .boundary(boundary_w), .first(first_w), .running(running_w),
        .div_out(div_out), .plus_one(plus_one),
        .cnt_o(cnt_w), .len_o(len_w)
    );

endmodule

// File: rtl/fracn_modctl_chk.sv
module fracn_modctl_chk #(
    parameter int NW = 6
) (
    input logic        clk,
    input logic        rst_n,
    input logic        div_out,
    input logic        plus_one,
    input logic        running,
    input logic [NW:0] cnt,
    input logic [NW:0] len,
    input logic [15:0] lfsr
);
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_quiet_in_reset: assert (!div_out && !plus_one);
        end
    end

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        div_out |=> !div_out);

    a_r2_count_below_len: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt < len));

    a_r3_choice_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !div_out) |=> ($stable(plus_one) && $stable(len)));

    a_r7_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (lfsr != 16'd0));

endmodule

bind fracn_modctl fracn_modctl_chk #(.NW(NW)) chk_i (
    .clk(clk), .rst_n(rst_n), .div_out(div_out), .plus_one(plus_one),
    .running(running_w), .cnt(cnt_w), .len(len_w), .lfsr(lfsr_w)
);

// File: tb/fracn_modctl_tb_top.sv
module fracn_modctl_tb_top;
    localparam int NW = 6;
    localparam int FW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NW-1:0] n_r = 6'd4;
    logic [FW-1:0] frac_r = '0;
    logic [1:0]    mode_r = 2'd0;
    logic [15:0]   seed_r = 16'd0;
    logic          div_out, plus_one;

    int checks = 0;
    int failures = 0;

    logic [FW-1:0] m_acc;
    logic [15:0]   m_lfsr;
    logic [1:0]    m_mode;
    logic          m_first;
    int            exp_len;
    logic          exp_sel;

    always #5 clk = ~clk;

    fracn_modctl #(.NW(NW), .FW(FW)) dut_i (
        .clk(clk), .rst_n(rst_n), .n_in(n_r), .frac_in(frac_r),
        .mode_in(mode_r), .seed_in(seed_r), .div_out(div_out), .plus_one(plus_one)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [15:0] m_step(input logic [15:0] q);
        return {q[14:0], q[15] ^ q[13] ^ q[12] ^ q[10]};
    endfunction

    // expected choice for the division that starts at the coming boundary
    task automatic model_next();
        logic          reload;
        logic [FW-1:0] b_acc;
        logic [15:0]   b_l;
        logic [FW:0]   s;
        reload = m_first || (mode_r != m_mode);
        b_acc  = reload ? ((mode_r == 2'd2) ? 8'd128 : 8'd0) : m_acc;
        b_l    = reload ? ((seed_r == 16'd0) ? 16'hACE1 : seed_r) : m_lfsr;
        if (mode_r == 2'd1) begin
            exp_sel = (b_l[15:8] < frac_r);
            m_lfsr  = m_step(b_l);
            m_acc   = b_acc;
        end else begin
            s       = {1'b0, b_acc} + {1'b0, frac_r};
            exp_sel = s[FW];
            m_acc   = s[FW-1:0];
            m_lfsr  = b_l;
        end
        m_mode  = mode_r;
        m_first = 1'b0;
        exp_len = int'(n_r) + int'(exp_sel);
    endtask

    // wait for the end of one division and check its length (R2)
    task automatic run_div(input int mid_n, output int len);
        len = 0;
        do begin
            @(negedge clk);
            len++;
            if (len == 1 && mid_n >= 0) n_r = mid_n[NW-1:0];
        end while (!div_out && len < 200);
        chk(len == exp_len, "R2 division length", len, exp_len);
        chk(plus_one == exp_sel, "R2 plus_one", int'(plus_one), int'(exp_sel));
    endtask

    // run cnt divisions with the current config; sum of lengths and N+1 count
    task automatic run_block(input int cnt, output int total, output int ones);
        int len;
        total = 0;
        ones  = 0;
        for (int i = 0; i < cnt; i++) begin
            model_next();
            run_div(-1, len);
            total += len;
            ones  += int'(exp_sel);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int tot, ones, len, nn, ff;
        int seq[4];
        void'($urandom(32'd2718));
        m_first = 1'b1;
        m_acc = '0; m_lfsr = 16'hACE1; m_mode = '0;

        // R1: outputs quiet during reset
        repeat (3) @(negedge clk);
        chk(!div_out && !plus_one, "R1 reset outputs", int'({div_out, plus_one}), 0);

        // R4: periodic 4.25 pattern, then R6 totals
        n_r = 6'd4; frac_r = 8'd64; mode_r = 2'd0;
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            model_next();
            run_div(-1, len);
            seq[i] = len;
        end
        chk(seq[0] == 4 && seq[1] == 4 && seq[2] == 4 && seq[3] == 5,
            "R4 periodic 4.25 pattern", seq[3], 5);
        run_block(256, tot, ones);
        chk(tot == 4 * 256 + 64, "R6 periodic total", tot, 4 * 256 + 64);

        // R5 + R10: shaped mode, residue reloaded at mid-scale
        mode_r = 2'd2;
        for (int i = 0; i < 4; i++) begin
            model_next();
            run_div(-1, len);
            seq[i] = len;
        end
        chk(seq[0] == 4 && seq[1] == 5 && seq[2] == 4 && seq[3] == 4,
            "R5 shaped pattern", seq[1], 5);
        run_block(256, tot, ones);
        chk(tot == 4 * 256 + 64, "R6 shaped total", tot, 4 * 256 + 64);

        // R9: zero fraction in every mode
        for (int md = 0; md < 4; md++) begin
            mode_r = md[1:0]; frac_r = 8'd0; n_r = 6'd9; seed_r = 16'h0F0F;
            run_block(32, tot, ones);
            chk(tot == 9 * 32, "R9 zero fraction total", tot, 9 * 32);
        end

        // R6 corner: maximum fraction, periodic
        mode_r = 2'd3; frac_r = 8'd255; n_r = 6'd3;
        run_block(256, tot, ones);
        chk(tot == 3 * 256 + 255, "R6 max fraction total", tot, 3 * 256 + 255);

        // R3: mid-division change of n_in applies only to the next division
        mode_r = 2'd0; frac_r = 8'd0; n_r = 6'd5;
        model_next();
        run_div(6, len);
        chk(len == 5, "R3 mid-division n change ignored", len, 5);
        model_next();
        run_div(-1, len);
        chk(len == 6, "R3 new n applied next", len, 6);

        // R7 + R8: randomized mode, long run
        mode_r = 2'd1; seed_r = 16'h1234; n_r = 6'd7; frac_r = 8'd100;
        run_block(16 * 256, tot, ones);
        chk(ones >= 1600 - 128 && ones <= 1600 + 128, "R8 random long-run proportion",
            ones, 1600);
        chk(tot == 7 * 4096 + ones, "R7 random total", tot, 7 * 4096 + ones);

        // R7: zero seed replaced, entered again via mode change
        mode_r = 2'd0;
        run_block(2, tot, ones);
        mode_r = 2'd1; seed_r = 16'd0; frac_r = 8'd128;
        run_block(64, tot, ones);
        chk(ones > 0 && ones < 64, "R7 zero seed dithers", ones, 32);

        // constrained random configurations (R4 R5 R6 R7 R10)
        for (int k = 0; k < 12; k++) begin
            nn = 2 + int'($urandom % 19);
            ff = int'($urandom % 256);
            mode_r = 2'($urandom % 4);
            n_r = nn[NW-1:0]; frac_r = ff[FW-1:0]; seed_r = 16'($urandom);
            run_block(256, tot, ones);
            if (mode_r != 2'd1)
                chk(tot == nn * 256 + ff, "R6 random config total", tot, nn * 256 + ff);
            else
                chk(tot == nn * 256 + ones, "R7 random config total", tot, nn * 256 + ones);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule